// File: doc/BRIEF.md
# Guarded Byte-Store Write Controller

This block sits between a CPU register bus and a small on-chip nonvolatile byte store. Software uses it to place an address and a data byte in holding registers and then start a programming cycle. A cycle can erase the byte, write into it, or do both as one step. Nothing is programmed unless software first sets an arming bit and then sets the go bit a few clocks later. The arming bit clears itself after a fixed window. While a cycle runs, the go bit stays set and the holding registers are frozen. When the cycle ends, the go bit clears and a level-sensitive ready interrupt can be raised.

A read request copies the byte at the held address into the data register on the next clock edge. Each read and each launched cycle drives a stall output to the CPU for a fixed number of clocks. A flash self-programming busy input blocks any new launch. The store itself is a register array. A cycle counter stands in for the programming time.

The register bus has three registers, chosen by `reg_sel`:

- 0 selects the address register.
- 1 selects the data register.
- 2 selects the control register, with these bits:
  - bit 0: arm
  - bit 1: go
  - bit 2: read request (write-only, reads back 0)
  - bit 3: interrupt enable
  - bits 5:4: mode

Top module: `nvm_write_ctrl`

## Requirements
- R1: The mode field selects what a launched cycle does to the addressed byte. 00 stores the data byte exactly. 01 sets the byte to all ones (0xFF). 10 stores the bitwise AND of the old byte and the data byte.
- R2: The go bit reads 1 for exactly T_COMBINED clocks in mode 00, and for exactly T_SINGLE clocks in modes 01 and 10. T_COMBINED is T_SINGLE*17/9 rounded to the nearest integer. The go bit then clears.
- R3: A control write with arm=1 and go=0 sets the arm bit. It reads 1 for the next ARM_WINDOW clocks (4 by default) and then clears by itself. A control write with go=1 starts a cycle only while the arm bit reads 1. Otherwise the go bit stays 0.
- R4: A control write with arm=1 and go=1 together does not set the arm bit. It starts no cycle unless the arm bit was already set.
- R5: A go write carrying mode 11 starts nothing. The go bit stays 0 and the stall output stays low.
- R6: While the go bit is 1, writes to the address register, the data register and the mode field are ignored. The running cycle uses the address, data and mode captured when it was launched.
- R7: A control write with the read bit set while idle loads the data register with the byte at the held address on that clock edge. It also raises the stall output for READ_STALL clocks (4 by default).
- R8: Launching a cycle raises the stall output for WRITE_STALL clocks (2 by default).
- R9: `irq_o` equals interrupt-enable AND `gie_i` AND NOT go, as a continuous level.
- R10: While `flash_busy_i` is 1, a go write starts no cycle.
- R11: After reset, all three registers read 0, `irq_o` and `stall_o` are 0, and every byte of the store reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| gie_i | input | 1 | Global interrupt enable |
| flash_busy_i | input | 1 | Flash self-programming in progress |
| irq_o | output | 1 | Ready interrupt, level |
| stall_o | output | 1 | CPU stall request |

## Verification
The bench builds the block with T_SINGLE=9, which makes T_COMBINED 17. With these values, every cycle duration can be counted edge by edge in a short run, and both the 9-clock and 17-clock lengths are checked exactly. It keeps ADDR_W=6, so the vector walk can reach the highest address (63) and the lowest address (0). The arm window and both stall lengths stay at their defaults of 4, 4 and 2. This places the last accepted go write and the first rejected one at fixed, nearby edges.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [1:0] {
      MODE_ERASE_WRITE = 2'b00,
      MODE_ERASE       = 2'b01,
      MODE_WRITE       = 2'b10,
      MODE_RSVD        = 2'b11
   } nvm_mode_e;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_DATA = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;

   localparam int CB_ARM  = 0;
   localparam int CB_GO   = 1;
   localparam int CB_RD   = 2;
   localparam int CB_IE   = 3;
   localparam int CB_MODE = 4;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_req,
   input  logic consume,
   output logic armed_o
);
   localparam int CW = $clog2(WINDOW + 1);

   if (WINDOW < 1) begin : g_bad_window
      $error("nvm_unlock: WINDOW must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (consume) begin
         cnt_q <= '0;
      end else if (arm_req) begin
         cnt_q <= CW'(WINDOW);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign armed_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
   import nvm_pkg::*;
#(
   parameter int T_SINGLE   = 18000,
   parameter int T_COMBINED = 34000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  nvm_mode_e mode,
   output logic      busy_o,
   output logic      done_o
);
   localparam int CW = $clog2(T_COMBINED + 1);

   if (T_SINGLE < 2) begin : g_bad_single
      $error("nvm_prog_timer: T_SINGLE must be at least 2");
   end
   if (T_COMBINED < T_SINGLE) begin : g_bad_comb
      $error("nvm_prog_timer: T_COMBINED must not be below T_SINGLE");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load_val;

   always_comb begin
      if (mode == MODE_ERASE_WRITE) load_val = CW'(T_COMBINED);
      else                          load_val = CW'(T_SINGLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start && cnt_q == '0) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/nvm_stall.sv
module nvm_stall #(
   parameter int RD_CYC = 4,
   parameter int WR_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_start,
   input  logic wr_start,
   output logic stall_o
);
   localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   if (RD_CYC < 1 || WR_CYC < 1) begin : g_bad_stall
      $error("nvm_stall: stall lengths must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (rd_start) begin
         cnt_q <= CW'(RD_CYC);
      end else if (wr_start) begin
         cnt_q <= CW'(WR_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign stall_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array
   import nvm_pkg::*;
#(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 8,
   parameter bit ERASED_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              commit,
   input  nvm_mode_e         op_mode,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("nvm_byte_array: ADDR_W out of range");
   end

   logic [DATA_W-1:0] rst_val;
   logic [DEPTH*DATA_W-1:0] flat;
   logic [DATA_W-1:0] old_val;
   logic [DATA_W-1:0] new_val;

   if (ERASED_RESET) begin : g_rst_ones
      assign rst_val = '1;
   end else begin : g_rst_zero
      assign rst_val = '0;
   end

   assign old_val = flat[op_addr*DATA_W +: DATA_W];

   always_comb begin
      unique case (op_mode)
         MODE_ERASE:       new_val = '1;
         MODE_WRITE:       new_val = old_val & op_data;
         MODE_ERASE_WRITE: new_val = op_data;
         default:          new_val = old_val;
      endcase
   end

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= rst_val;
         end else if (commit && op_addr == ADDR_W'(w)) begin
            word_q <= new_val;
         end
      end
      assign flat[w*DATA_W +: DATA_W] = word_q;
   end

   assign rd_data = flat[rd_addr*DATA_W +: DATA_W];
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
   import nvm_pkg::*;
#(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 8,
   parameter int T_SINGLE     = 18000,
   parameter int ARM_WINDOW   = 4,
   parameter int READ_STALL   = 4,
   parameter int WRITE_STALL  = 2,
   parameter bit ERASED_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              gie_i,
   input  logic              flash_busy_i,
   output logic              irq_o,
   output logic              stall_o
);
   localparam int T_COMBINED = (T_SINGLE * 17 + 4) / 9;

   if (DATA_W < 6) begin : g_bad_data
      $error("nvm_write_ctrl: DATA_W must hold the control bits");
   end
   if (ADDR_W > DATA_W) begin : g_bad_aw
      $error("nvm_write_ctrl: ADDR_W must fit the register bus");
   end

   logic [ADDR_W-1:0] addr_q, op_addr_q;
   logic [DATA_W-1:0] data_q, op_data_q;
   nvm_mode_e         mode_q, op_mode_q, w_mode;
   logic              ie_q;
   logic              strobe, done, armed;
   logic [DATA_W-1:0] rd_byte;

   logic ctrl_wr, idle, rd_req, arm_req, launch;

   assign w_mode  = nvm_mode_e'(reg_wdata[CB_MODE +: 2]);
   assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
   assign idle    = !strobe;
   assign rd_req  = ctrl_wr && reg_wdata[CB_RD] && idle;
   assign arm_req = ctrl_wr && reg_wdata[CB_ARM] && !reg_wdata[CB_GO] && idle;
   assign launch  = ctrl_wr && reg_wdata[CB_GO] && !reg_wdata[CB_RD] && idle
                    && armed && !flash_busy_i && (w_mode != MODE_RSVD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q    <= '0;
         data_q    <= '0;
         mode_q    <= MODE_ERASE_WRITE;
         ie_q      <= 1'b0;
         op_addr_q <= '0;
         op_data_q <= '0;
         op_mode_q <= MODE_ERASE_WRITE;
      end else begin
         if (reg_wr && reg_sel == SEL_ADDR && idle)
            addr_q <= reg_wdata[ADDR_W-1:0];
         if (reg_wr && reg_sel == SEL_DATA && idle)
            data_q <= reg_wdata;
         else if (rd_req)
            data_q <= rd_byte;
         if (ctrl_wr) begin
            ie_q <= reg_wdata[CB_IE];
            if (idle) mode_q <= w_mode;
         end
         if (launch) begin
            op_addr_q <= addr_q;
            op_data_q <= data_q;
            op_mode_q <= w_mode;
         end
      end
   end

   nvm_unlock #(.WINDOW(ARM_WINDOW)) i_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_req (arm_req),
      .consume (launch),
      .armed_o (armed)
   );

   nvm_prog_timer #(.T_SINGLE(T_SINGLE), .T_COMBINED(T_COMBINED)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (launch),
      .mode   (w_mode),
      .busy_o (strobe),
      .done_o (done)
   );

   nvm_stall #(.RD_CYC(READ_STALL), .WR_CYC(WRITE_STALL)) i_stall (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_start (rd_req),
      .wr_start (launch),
      .stall_o  (stall_o)
   );

   nvm_byte_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASED_RESET(ERASED_RESET)
   ) i_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (addr_q),
      .rd_data (rd_byte),
      .commit  (done),
      .op_mode (op_mode_q),
      .op_addr (op_addr_q),
      .op_data (op_data_q)
   );

   logic [DATA_W-1:0] ctrl_view;
   always_comb begin
      ctrl_view = '0;
      ctrl_view[CB_ARM]      = armed;
      ctrl_view[CB_GO]       = strobe;
      ctrl_view[CB_IE]       = ie_q;
      ctrl_view[CB_MODE +: 2] = mode_q;
   end

   always_comb begin
      unique case (reg_sel)
         SEL_ADDR: reg_rdata = DATA_W'(addr_q);
         SEL_DATA: reg_rdata = data_q;
         SEL_CTRL: reg_rdata = ctrl_view;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq_o = ie_q && gie_i && !strobe;
endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk #(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 8,
   parameter int ARM_WINDOW = 4,
   parameter int T_COMBINED = 34000,
   parameter int STALL_MAX  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              armed,
   input logic              arm_req,
   input logic              strobe,
   input logic              start_any,
   input logic              flash_busy_i,
   input logic              ctrl_wr,
   input logic [1:0]        w_mode,
   input logic              irq_o,
   input logic              stall_o,
   input logic [ADDR_W-1:0] addr_q,
   input logic [DATA_W-1:0] data_q
);
   int unsigned arm_run, strobe_run, stall_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_run    <= 0;
         strobe_run <= 0;
         stall_run  <= 0;
      end else begin
         arm_run    <= arm_req ? 0 : (armed ? arm_run + 1 : 0);
         strobe_run <= strobe ? strobe_run + 1 : 0;
         stall_run  <= start_any ? 0 : (stall_o ? stall_run + 1 : 0);
      end
   end

   a_r3_arm_window: assert property (@(posedge clk) disable iff (!rst_n)
      arm_run <= ARM_WINDOW);
   a_r3_launch_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> $past(armed));
   a_r10_flash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> !$past(flash_busy_i));
   a_r9_no_irq_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !irq_o);
   a_r6_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> ($stable(addr_q) && $stable(data_q)));
   a_r5_reserved_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && w_mode == 2'b11 && !strobe) |=> !strobe);
   a_r2_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_run <= T_COMBINED);
   a_r7_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
      stall_run <= STALL_MAX);
endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARM_WINDOW(ARM_WINDOW),
   .T_COMBINED(T_COMBINED),
   .STALL_MAX((READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .armed        (armed),
   .arm_req      (arm_req),
   .strobe       (strobe),
   .start_any    (rd_req || launch),
   .flash_busy_i (flash_busy_i),
   .ctrl_wr      (ctrl_wr),
   .w_mode       (reg_wdata[4 +: 2]),
   .irq_o        (irq_o),
   .stall_o      (stall_o),
   .addr_q       (addr_q),
   .data_q       (data_q)
);

// File: tb/test_nvm_write_ctrl.sv
module test_nvm_write_ctrl;
   localparam int TS = 9;
   localparam int TC = (TS * 17 + 4) / 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       gie_i = 1'b0;
   logic       flash_busy_i = 1'b0;
   logic       irq_o, stall_o;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   nvm_write_ctrl #(.T_SINGLE(TS)) i_nvm_write_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie_i(gie_i),
      .flash_busy_i(flash_busy_i), .irq_o(irq_o), .stall_o(stall_o)
   );

   // vector: [31:24] address, [17:16] mode, [15:8] data, [7:0] expected byte
   localparam logic [31:0] VEC [8] = '{
      32'h03_00_A5_A5, 32'h03_02_0F_05, 32'h03_01_00_FF, 32'h03_02_3C_3C,
      32'h3F_00_00_00, 32'h00_02_81_81, 32'h3F_02_FF_00, 32'h00_00_7E_7E
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] sel, output logic [7:0] v);
      reg_sel = sel; #1; v = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // counts go-bit and stall cycles from the negedge after launch
   task automatic measure(output int go_n, output int st_n, output int irq_busy);
      logic [7:0] v;
      go_n = 0; st_n = 0; irq_busy = 0;
      for (int k = 0; k < 100; k++) begin
         rd_reg(2'd2, v);
         if (!v[1]) break;
         go_n++;
         if (stall_o) st_n++;
         if (irq_o) irq_busy++;
         @(negedge clk);
      end
   endtask

   task automatic read_byte(input logic [7:0] a, output logic [7:0] b, output int st_n);
      bus_wr(2'd0, a);
      bus_wr(2'd2, 8'h0C);   // read request, interrupt enable kept
      st_n = 0;
      for (int k = 0; k < 20 && stall_o; k++) begin
         st_n++;
         @(negedge clk);
      end
      rd_reg(2'd1, b);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         fails++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v, b;
      int g, s, ib;
      idle(3);
      rst_n = 1'b1;
      gie_i = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd_reg(2'd0, v); chk("R11 addr", v, 0);
      rd_reg(2'd1, v); chk("R11 data", v, 0);
      rd_reg(2'd2, v); chk("R11 ctrl", v, 0);
      chk("R11 irq", irq_o, 0);
      chk("R11 stall", stall_o, 0);
      read_byte(8'd17, b, s); chk("R11 erased byte", b, 8'hFF);
      chk("R7 read stall", s, 4);

      // vector walk: R1, R2, R8, R9, R7
      foreach (VEC[i]) begin
         bus_wr(2'd0, VEC[i][31:24]);
         bus_wr(2'd1, VEC[i][15:8]);
         bus_wr(2'd2, {2'b00, VEC[i][17:16], 4'b1001});
         bus_wr(2'd2, {2'b00, VEC[i][17:16], 4'b1010});
         measure(g, s, ib);
         chk("R2 go duration", g, (VEC[i][17:16] == 2'b00) ? TC : TS);
         chk("R8 launch stall", s, 2);
         chk("R9 irq low while busy", ib, 0);
         chk("R9 irq high when idle", irq_o, 1);
         read_byte(VEC[i][31:24], b, s);
         chk("R1 stored byte", b, VEC[i][7:0]);
      end

      // R9 global enable gates interrupt
      gie_i = 1'b0; #1;
      chk("R9 irq gated by gie", irq_o, 0);
      gie_i = 1'b1;

      // R3 window: arm bit reads 1 for four cycles, then clears
      bus_wr(2'd2, 8'h01);
      rd_reg(2'd2, v); chk("R3 armed", v[0], 1);
      idle(3);
      rd_reg(2'd2, v); chk("R3 still armed", v[0], 1);
      idle(1);
      rd_reg(2'd2, v); chk("R3 arm cleared", v[0], 0);
      bus_wr(2'd2, 8'h02);
      rd_reg(2'd2, v); chk("R3 late go ignored", v[1], 0);
      chk("R3 no stall late go", stall_o, 0);

      // R3 last accepted slot
      bus_wr(2'd0, 8'd9);
      bus_wr(2'd1, 8'h5A);
      bus_wr(2'd2, 8'h01);
      idle(3);
      bus_wr(2'd2, 8'h02);
      measure(g, s, ib);
      chk("R3 go in fourth cycle", g, TC);
      read_byte(8'd9, b, s); chk("R3 byte", b, 8'h5A);

      // R4 arm and go in the same write
      bus_wr(2'd2, 8'h03);
      rd_reg(2'd2, v); chk("R4 arm and go together", v[1:0], 0);
      bus_wr(2'd2, 8'h02);
      rd_reg(2'd2, v); chk("R4 follow-up go ignored", v[1], 0);

      // R5 reserved mode
      bus_wr(2'd2, 8'h31);
      bus_wr(2'd2, 8'h32);
      rd_reg(2'd2, v); chk("R5 reserved no go", v[1], 0);
      chk("R5 reserved no stall", stall_o, 0);
      read_byte(8'd9, b, s); chk("R5 byte unchanged", b, 8'h5A);

      // R10 flash busy
      flash_busy_i = 1'b1;
      bus_wr(2'd1, 8'h00);
      bus_wr(2'd2, 8'h01);
      bus_wr(2'd2, 8'h02);
      rd_reg(2'd2, v); chk("R10 blocked by flash", v[1], 0);
      flash_busy_i = 1'b0;
      read_byte(8'd9, b, s); chk("R10 byte unchanged", b, 8'h5A);

      // R6 frozen registers during a cycle
      bus_wr(2'd0, 8'd5);
      bus_wr(2'd1, 8'h11);
      bus_wr(2'd2, 8'h01);
      bus_wr(2'd2, 8'h02);
      bus_wr(2'd0, 8'd7);
      bus_wr(2'd1, 8'h22);
      bus_wr(2'd2, 8'h11);
      measure(g, s, ib);
      chk("R6 mode held", g, TC - 3);
      rd_reg(2'd0, v); chk("R6 addr held", v, 5);
      rd_reg(2'd1, v); chk("R6 data held", v, 8'h11);
      rd_reg(2'd2, v); chk("R6 mode field held", v[5:4], 0);
      read_byte(8'd5, b, s); chk("R6 launched byte", b, 8'h11);
      read_byte(8'd7, b, s); chk("R6 other byte untouched", b, 8'hFF);

      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule